// File: doc/BRIEF.md
# Prescaled Interval Timer PWM

This block holds up to three timer channels. Each channel drives one pulse-width-modulated output from its own counter. The counter steps on a tick from a power-of-two prescaler. It runs upward or downward and wraps either at a programmed interval or at the full counter width. A channel's output takes its active level at the start of each period and drops to the inactive level once the number of ticks elapsed in that period reaches the match value. The output can be inverted, forced low (blanked), or held by freezing the counter.

Software drives each channel through a small word-addressed register bus. A write takes effect on the clock edge at which `bus_we` is high. A read is combinational from `bus_addr`. Each channel has four registers: clock control, counter control, interval and match. New interval and match values reach the waveform only at the next wrap, so an update never cuts a period short. A restart command reloads the counter on the clock after it is written and picks up any pending values at the same time. The external-source and edge-select bits in clock control are kept for software only. Counting always uses `clk`.

Top module: `interval_pwm_timer`

## Requirements
- R1: The word address selects the register. Clock control is at 0+c, counter control at 3+c, interval at 9+c and match at 12+c, for channel c in 0..2. Any other address reads 0, and a write to it changes nothing.
- R2: After reset every register reads 0, except counter control, which reads 0x21 (frozen and blanked). Every output is low.
- R3: Clock control stores bits 6:0 and reads them back, with the upper bits read as 0. Bit 0 enables the prescaler and bits 4:1 hold its exponent N. Bits 5 and 6 are storage only: the counting rate does not depend on them.
- R4: Counter control stores bits 6:0. Bit 4 (restart) always reads 0. Writing it with 1 restarts the channel on the following clock: the count goes to 0 when counting up or to the interval when counting down, the prescaler phase clears, and the pending interval and match values load.
- R5: With bit 0 of clock control set, the counter advances once every 2^(N+1) clocks. With bit 0 clear it advances every clock.
- R6: Counter control bit 1 set makes the counter wrap after the interval value, giving a period of interval+1 ticks. With bit 1 clear the counter wraps at 2^CNT_W-1.
- R7: Counter control bit 2 selects counting down. With polarity (bit 6) at 0 the output is high while the number of ticks elapsed in the period is below the match value and low otherwise. Polarity 1 swaps the two levels. Counting up and counting down give the same waveform. A match of 0 gives a constant inactive level, and a match above the interval gives a constant active level.
- R8: With counter control bit 3 (match enable) clear, the output stays at the active level.
- R9: Counter control bit 5 set drives the output low whatever the polarity.
- R10: Counter control bit 0 set freezes the counter and the prescaler, so the output holds its level.
- R11: A new interval or match value written while the channel runs takes effect at the next wrap, not in the current period.
- R12: Interval and match keep only the low CNT_W bits of a write.
- R13: A write to one channel does not change the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and for counting |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | One waveform per channel, registered |

## Verification
A sweep restarts the channels, in rotation, with every combination of: prescaler off or on with two exponents, intervals from 0 to 5, every match from 0 to two above the interval, both count directions and both polarities. Each output is compared every cycle against the formula "elapsed ticks mod (interval+1) below match, xor polarity", where elapsed ticks is (cycles since restart) divided by the divisor. The sweep separates a wrong divisor, a wrap one tick off, a wrong reload value for counting down and a wrong polarity, and the match values at 0 and above the interval reach both constant-level corners. Further directed patterns cover a few cases. A match change made just after a restart shows whether the update waits for the wrap. A run with interval mode off passes the interval, which proves the wrap at full width. The freeze, blank and match-disable bits each get a pattern whose running waveform would differ from the held one. A second channel is run while the other outputs are watched.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int CTL_W   = 7;
  localparam int PSC_W   = 4;
  localparam int PHASE_W = 2 ** PSC_W;

  // Word-address bases; channel c sits at base + c.
  localparam int CLKCTL_BASE = 0;
  localparam int CNTCTL_BASE = 3;
  localparam int PERIOD_BASE = 9;
  localparam int DUTY_BASE   = 12;

  localparam logic [CTL_W-1:0] CNTCTL_RESET = 7'h21;

  typedef struct packed {
    logic             edge_fall;
    logic             src_ext;
    logic [PSC_W-1:0] psc_val;
    logic             psc_en;
  } clk_ctl_t;

  typedef struct packed {
    logic pol;
    logic blank;
    logic restart;
    logic cmp_en;
    logic down;
    logic wrap_int;
    logic freeze;
  } cnt_ctl_t;

  // Last phase value before a tick: divisor 2^(n+1) minus one.
  function automatic logic [PHASE_W-1:0] phase_top(input logic [PSC_W-1:0] n);
    logic [31:0] v;
    v = (32'd1 << (32'(n) + 32'd1)) - 32'd1;
    return v[PHASE_W-1:0];
  endfunction
endpackage

// File: rtl/ptm_regs.sv
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NCH-1:0]              psc_en_o,
  output logic [NCH-1:0][PSC_W-1:0]   psc_val_o,
  output cnt_ctl_t [NCH-1:0]          cnt_ctl_o,
  output logic [NCH-1:0][CNT_W-1:0]   period_o,
  output logic [NCH-1:0][CNT_W-1:0]   duty_o,
  output logic [NCH-1:0]              restart_o
);
  localparam int PAD_CTL = DATA_W - CTL_W;
  localparam int PAD_CNT = DATA_W - CNT_W;

  clk_ctl_t [NCH-1:0]        clk_q;
  cnt_ctl_t [NCH-1:0]        cnt_q;
  logic [NCH-1:0][CNT_W-1:0] per_q;
  logic [NCH-1:0][CNT_W-1:0] duty_q;
  logic [NCH-1:0]            rst_q;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int base, input int ch);
    return a == ADDR_W'(base + ch);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        clk_q[c]  <= '0;
        cnt_q[c]  <= cnt_ctl_t'(CNTCTL_RESET);
        per_q[c]  <= '0;
        duty_q[c] <= '0;
        rst_q[c]  <= 1'b0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        rst_q[c] <= bus_we && hit(bus_addr, CNTCTL_BASE, c) && bus_wdata[4];
        if (bus_we && hit(bus_addr, CLKCTL_BASE, c))
          clk_q[c] <= clk_ctl_t'(bus_wdata[CTL_W-1:0]);
        if (bus_we && hit(bus_addr, CNTCTL_BASE, c)) begin
          cnt_q[c]         <= cnt_ctl_t'(bus_wdata[CTL_W-1:0]);
          cnt_q[c].restart <= 1'b0;
        end
        if (bus_we && hit(bus_addr, PERIOD_BASE, c))
          per_q[c] <= bus_wdata[CNT_W-1:0];
        if (bus_we && hit(bus_addr, DUTY_BASE, c))
          duty_q[c] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit(bus_addr, CLKCTL_BASE, c)) bus_rdata = {{PAD_CTL{1'b0}}, clk_q[c]};
      if (hit(bus_addr, CNTCTL_BASE, c)) bus_rdata = {{PAD_CTL{1'b0}}, cnt_q[c]};
      if (hit(bus_addr, PERIOD_BASE, c)) bus_rdata = {{PAD_CNT{1'b0}}, per_q[c]};
      if (hit(bus_addr, DUTY_BASE, c))   bus_rdata = {{PAD_CNT{1'b0}}, duty_q[c]};
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      psc_en_o[c]  = clk_q[c].psc_en;
      psc_val_o[c] = clk_q[c].psc_val;
    end
  end

  assign cnt_ctl_o = cnt_q;
  assign period_o  = per_q;
  assign duty_o    = duty_q;
  assign restart_o = rst_q;
endmodule

// File: rtl/ptm_prescale.sv
module ptm_prescale
  import ptm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             psc_en,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] top;
  logic               phase_end;

  assign top       = phase_top(psc_val);
  assign phase_end = phase_q >= top;
  assign tick      = run && (!psc_en || phase_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (restart)           phase_q <= '0;
    else if (run && psc_en)     phase_q <= phase_end ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ptm_chan.sv
module ptm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             down,
  input  logic             wrap_int,
  input  logic             cmp_en,
  input  logic             blank,
  input  logic             pol,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             wave,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic [CNT_W-1:0] lim_new, lim_cur, elapsed;
  logic             at_end, active, reload;

  function automatic logic [CNT_W-1:0] ticks_done(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] lim,
                                                  input logic dn);
    if (!dn)      return c;
    else if (c > lim) return '0;
    else          return lim - c;
  endfunction

  assign lim_new  = wrap_int ? period : FULL;
  assign lim_cur  = wrap_int ? per_q  : FULL;
  assign at_end   = down ? (cnt_q == '0) : (cnt_q >= lim_cur);
  assign wrap_evt = tick && at_end;
  assign reload   = restart || wrap_evt;
  assign elapsed  = ticks_done(cnt_q, lim_cur, down);
  assign active   = !cmp_en || (elapsed < duty_q);
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      wave   <= 1'b0;
    end else begin
      wave <= !blank && (active ^ pol);
      if (reload) begin
        per_q  <= period;
        duty_q <= duty;
        cnt_q  <= down ? lim_new : '0;
      end else if (tick) begin
        cnt_q <= down ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/interval_pwm_timer.sv
module interval_pwm_timer
  import ptm_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]            psc_en;
  logic [NCH-1:0][PSC_W-1:0] psc_val;
  cnt_ctl_t [NCH-1:0]        cnt_ctl;
  logic [NCH-1:0][CNT_W-1:0] period, duty;
  logic [NCH-1:0]            restart;

  // Named internal events for the checker.
  logic [NCH*CNT_W-1:0] dbg_cnt;
  logic [NCH-1:0]       dbg_freeze, dbg_blank, dbg_down, dbg_tick, dbg_wrap;

  ptm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .psc_en_o(psc_en), .psc_val_o(psc_val),
    .cnt_ctl_o(cnt_ctl), .period_o(period), .duty_o(duty), .restart_o(restart)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             wrap_evt;

    ptm_prescale u_psc (
      .clk(clk), .rst_n(rst_n), .run(!cnt_ctl[g].freeze), .restart(restart[g]),
      .psc_en(psc_en[g]), .psc_val(psc_val[g]), .tick(tick)
    );

    ptm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart[g]),
      .down(cnt_ctl[g].down), .wrap_int(cnt_ctl[g].wrap_int), .cmp_en(cnt_ctl[g].cmp_en),
      .blank(cnt_ctl[g].blank), .pol(cnt_ctl[g].pol), .period(period[g]), .duty(duty[g]),
      .wave(pwm_out[g]), .count(count), .wrap_evt(wrap_evt)
    );

    assign dbg_cnt[g*CNT_W +: CNT_W] = count;
    assign dbg_freeze[g] = cnt_ctl[g].freeze;
    assign dbg_blank[g]  = cnt_ctl[g].blank;
    assign dbg_down[g]   = cnt_ctl[g].down;
    assign dbg_tick[g]   = tick;
    assign dbg_wrap[g]   = wrap_evt;
  end
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
  parameter int NCH    = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NCH-1:0]       pwm_out,
  input logic [NCH*CNT_W-1:0] dbg_cnt,
  input logic [NCH-1:0]       dbg_freeze,
  input logic [NCH-1:0]       dbg_blank,
  input logic [NCH-1:0]       dbg_down,
  input logic [NCH-1:0]       dbg_restart
);
  // R4: restart bit of counter control never reads back as 1.
  a_r4_restart_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(3) && bus_addr < ADDR_W'(3 + NCH)) |-> !bus_rdata[4]);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R9: a blanked channel drives low on the next cycle.
    a_r9_blank_low: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_blank[g] |=> !pwm_out[g]);
    // R10: a frozen channel keeps its count unless restarted.
    a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_freeze[g] && !dbg_restart[g]) |=> $stable(dbg_cnt[g*CNT_W +: CNT_W]));
    // R4: a restart while counting up leaves the count at zero.
    a_r4_restart_up_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_restart[g] && !dbg_down[g]) |=> (dbg_cnt[g*CNT_W +: CNT_W] == '0));
  end
endmodule

bind interval_pwm_timer ptm_checker #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .dbg_cnt(dbg_cnt), .dbg_freeze(dbg_freeze), .dbg_blank(dbg_blank), .dbg_down(dbg_down),
  .dbg_restart(restart)
);

// File: tb/interval_pwm_timer_tb.sv
`timescale 1ns/100ps
module interval_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  pwm_out;
  int vectors = 0;
  int errors  = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  interval_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic exp_lvl(int j, int d, int i, int m, bit pol);
    logic act;
    act = (((j - 1) / d) % (i + 1)) < m;
    return act ^ pol;
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a[3:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd_check(string req, int a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a[3:0];
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: addr %0d actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  // Caller stands just after the edge that applied the restart.
  task automatic run_wave(int ch, int n, int d, int i, int m, bit pol, string req);
    @(negedge clk);
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      check_bit(req, pwm_out[ch], exp_lvl(j, d, i, m, pol));
    end
  endtask

  function automatic logic [31:0] reset_val(int a);
    return (a >= 3 && a <= 5) ? 32'h21 : 32'h0;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int run_idx;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R2: reset values; R1: unmapped addresses read 0
    for (int a = 0; a < 16; a++) rd_check("R2 reset value", a, reset_val(a));
    @(negedge clk);
    check_bit("R2 outputs low after reset", |pwm_out, 1'b0);

    // R1: write to unmapped address has no effect
    wr(7, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) rd_check("R1 unmapped write ignored", a, reset_val(a));

    // R3: clock control readback, upper bits zero
    wr(1, 32'hFFFF_FFFF);
    rd_check("R3 clock control readback", 1, 32'h7F);
    wr(1, 32'h0);
    // R4: restart bit reads zero
    wr(5, 32'h7F);
    rd_check("R4 restart reads zero", 5, 32'h6F);
    wr(5, 32'h21);
    // R12: interval and match masking
    wr(11, 32'hFFFF_ABCD);
    rd_check("R12 interval masked", 11, 32'hABCD);
    wr(14, 32'h1234_5678);
    rd_check("R12 match masked", 14, 32'h5678);

    // R5/R6/R7 sweep; R3 storage-only bits mixed in
    run_idx = 0;
    for (int p = 0; p < 3; p++) begin
      foreach (int_list_dummy[ii]) ;
    end
    for (int p = 0; p < 3; p++) begin
      for (int ii = 0; ii < 5; ii++) begin
        int iv;
        iv = (ii == 4) ? 5 : ii;
        for (int m = 0; m <= iv + 2; m++) begin
          for (int dn = 0; dn < 2; dn++) begin
            for (int pl = 0; pl < 2; pl++) begin
              int ch, d;
              logic [31:0] cc;
              ch = run_idx % 3;
              run_idx++;
              d  = (p == 0) ? 1 : ((p == 1) ? 2 : 4);
              cc = (p == 0) ? 32'h0 : ((p == 1) ? 32'h1 : 32'h3);
              if (m % 2 == 1) cc = cc | 32'h60;
              wr(0 + ch, cc);
              wr(9 + ch, iv);
              wr(12 + ch, m);
              wr(3 + ch, 32'h1A | (dn << 2) | (pl << 6));
              @(posedge clk); #1;
              run_wave(ch, 2 * (iv + 1) * d + 2, d, iv, m, pl[0], "R5/R6/R7 sweep");
            end
          end
        end
      end
    end
    rd_check("R3 storage bits kept", 0, 32'h63);

    // Park all channels frozen and blanked.
    for (int c = 0; c < 3; c++) begin
      wr(3 + c, 32'h21);
      wr(0 + c, 32'h0);
    end

    // R11: match change right after restart waits for the wrap
    wr(9, 3);
    wr(12, 2);
    wr(3, 32'h1A);
    wr(12, 0);
    @(negedge clk);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      check_bit("R11 match update at wrap", pwm_out[0], (j <= 4) ? exp_lvl(j, 1, 3, 2, 0) : 1'b0);
    end

    // R10: freeze holds the level
    wr(9, 9);
    wr(12, 1);
    wr(3, 32'h1A);
    wr(3, 32'h0B);
    @(negedge clk);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      check_bit("R10 frozen output holds", pwm_out[0], 1'b1);
    end

    // R6: without interval mode the count runs past the interval
    wr(9, 3);
    wr(12, 5);
    wr(3, 32'h18);
    @(posedge clk); #1;
    @(negedge clk);
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      check_bit("R6 full-width wrap", pwm_out[0], (j - 1) < 5);
    end

    // R8: match compare disabled gives constant active level
    wr(12, 1);
    wr(3, 32'h12);
    @(posedge clk); #1;
    @(negedge clk);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      check_bit("R8 compare disabled", pwm_out[0], 1'b1);
    end

    // R9: blank forces low even with inverted polarity
    wr(12, 0);
    wr(3, 32'h6A);
    @(negedge clk);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      check_bit("R9 blanked output", pwm_out[0], 1'b0);
    end

    // R13: channel 1 runs while 0 and 2 stay blanked
    wr(0 + 1, 32'h0);
    wr(9 + 1, 1);
    wr(12 + 1, 1);
    wr(3 + 1, 32'h1A);
    @(posedge clk); #1;
    @(negedge clk);
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      check_bit("R13 channel 1 waveform", pwm_out[1], exp_lvl(j, 1, 1, 1, 0));
      check_bit("R13 channel 0 untouched", pwm_out[0], 1'b0);
      check_bit("R13 channel 2 untouched", pwm_out[2], 1'b0);
    end

    done = 1;
    summary();
    $finish;
  end

  int int_list_dummy [0:0];
endmodule